// File: doc/BRIEF.md
# ASID-Qualified Breakpoint Comparator

This block watches a processor's retired-instruction stream and its operand accesses and signals when either touches a programmed breakpoint. Each breakpoint names a 40-bit virtual location: a 32-bit address with an 8-bit address space identifier (ASID) above it. Every breakpoint decides for itself whether the ASID must also match. If it does not, any address space is accepted. The block holds four instruction breakpoints and one operand breakpoint. The operand breakpoint also compares the access data under a programmable bit mask.

Software or a debug controller loads the breakpoints through a one-cycle register write port. The write port takes a register select and a 32-bit word. The processor side presents one retired program counter per cycle with a valid strobe, and optionally one operand access per cycle with its own strobe. Both sides share the current ASID. One clock later the block answers with a per-register hit vector, an operand hit flag and a combined trigger. All three are single-cycle pulses. Halting the processor on a trigger is left to the logic that consumes them.

Top module: `asid_bkpt_cmp`

## Requirements
- R1: After reset every breakpoint is disabled, the data mask is zero and all outputs are low, so no compare produces a hit until a control word is written.
- R2: An enabled instruction breakpoint whose ASID-include bit is clear hits when `pc_addr` equals its stored address, whatever the value of `cur_asid`.
- R3: An enabled instruction breakpoint whose ASID-include bit is set hits only when `pc_addr` equals its stored address and `cur_asid` equals its stored ASID.
- R4: An instruction breakpoint whose enable bit is clear never sets its hit bit, even when address and ASID both match.
- R5: Bit k of `pc_hit_vec` belongs to instruction breakpoint k. Several bits may be set in the same cycle when several breakpoints match.
- R6: Outputs are registered. A compare presented with its valid strobe at clock edge N shows at edge N+1 and lasts exactly one cycle. No output is raised for a cycle whose strobe was low.
- R7: The operand breakpoint, when enabled, hits only if `op_addr` equals its stored address and the data matches. If its ASID-include bit is set, `cur_asid` must also equal its stored ASID.
- R8: Operand data matches when `op_data` equals the stored data in every bit where the mask is 1. Mask bits that are 0 are ignored.
- R9: A register write takes effect from the next compare cycle. A compare presented at the same edge as a write still uses the old value.
- R10: The write select map is as follows. Selects 0-3 hold instruction addresses 0-3. Selects 4-7 hold instruction ASIDs 0-3, in `wr_data[7:0]`. Select 8 holds the operand address, 9 the operand ASID, 10 the operand data and 11 the data mask. Select 12 holds the control word. Writes to selects 13-15 change nothing.
- R11: In the control word, bits [3:0] enable instruction breakpoints 0-3 and bits [7:4] set their ASID-include bits. Bit 8 enables the operand breakpoint and bit 9 is its ASID-include bit. `trig` is the OR of all hit outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| pc_valid | input | 1 | Retired instruction strobe |
| pc_addr | input | 32 | Retired instruction address |
| cur_asid | input | 8 | Current address space identifier |
| op_valid | input | 1 | Operand access strobe |
| op_addr | input | 32 | Operand address |
| op_data | input | 32 | Operand data |
| pc_hit_vec | output | 4 | Per-register instruction hit pulse |
| op_hit | output | 1 | Operand breakpoint hit pulse |
| trig | output | 1 | Combined trigger pulse |

## Verification
On every cycle, the in-line assertions check the following. Each hit bit comes from a compare strobe one edge earlier and from a breakpoint that was enabled then. The address matched, and the ASID matched wherever inclusion was on. An operand hit agrees with the stored data under the mask. A write to an unmapped select leaves the stored registers unchanged. Other behaviour needs the bench's scenarios to show it. These cases are that a matching compare really does raise a hit, that several registers fire together, and that a write racing a compare at the same edge is not yet seen. They also include that a zero mask makes data irrelevant and that the reset state ignores an all-zero compare.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int ADDR_W_DEF = 32;
  localparam int DATA_W_DEF = 32;
  localparam int ASID_W_DEF = 8;
  localparam int NUM_PC_DEF = 4;

  // Layout of the control word for a bank of n instruction breakpoints.
  function automatic int ctl_pc_incl_lsb(input int n);
    return n;
  endfunction
  function automatic int ctl_op_en_bit(input int n);
    return 2 * n;
  endfunction
  function automatic int ctl_op_incl_bit(input int n);
    return 2 * n + 1;
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = NUM_PC_DEF,
  parameter int AW     = ADDR_W_DEF,
  parameter int DW     = DATA_W_DEF,
  parameter int SW     = ASID_W_DEF,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [NUM_PC-1:0][AW-1:0] pc_ref_addr,
  output logic [NUM_PC-1:0][SW-1:0] pc_ref_asid,
  output logic [NUM_PC-1:0]        pc_en,
  output logic [NUM_PC-1:0]        pc_incl,
  output logic [AW-1:0]            op_ref_addr,
  output logic [SW-1:0]            op_ref_asid,
  output logic [DW-1:0]            op_ref_data,
  output logic [DW-1:0]            op_mask,
  output logic                     op_en,
  output logic                     op_incl
);
  localparam int SEL_PCA  = 0;
  localparam int SEL_PCS  = NUM_PC;
  localparam int SEL_OPA  = 2 * NUM_PC;
  localparam int SEL_OPS  = SEL_OPA + 1;
  localparam int SEL_OPD  = SEL_OPA + 2;
  localparam int SEL_MSK  = SEL_OPA + 3;
  localparam int SEL_CTL  = SEL_OPA + 4;
  localparam int CTL_W    = 2 * NUM_PC + 2;

  logic [NUM_PC-1:0][AW-1:0] pca_d;
  logic [NUM_PC-1:0][SW-1:0] pcs_d;
  logic [AW-1:0]             opa_d;
  logic [SW-1:0]             ops_d;
  logic [DW-1:0]             opd_d, msk_d;
  logic [CTL_W-1:0]          ctl_d, ctl_q;

  // Next-state: each register loads only on its own select.
  always_comb begin
    pca_d = pc_ref_addr;
    pcs_d = pc_ref_asid;
    opa_d = op_ref_addr;
    ops_d = op_ref_asid;
    opd_d = op_ref_data;
    msk_d = op_mask;
    ctl_d = ctl_q;
    if (wr_en) begin
      for (int k = 0; k < NUM_PC; k++) begin
        if (wr_sel == SEL_W'(SEL_PCA + k)) pca_d[k] = wr_data[AW-1:0];
        if (wr_sel == SEL_W'(SEL_PCS + k)) pcs_d[k] = wr_data[SW-1:0];
      end
      if (wr_sel == SEL_W'(SEL_OPA)) opa_d = wr_data[AW-1:0];
      if (wr_sel == SEL_W'(SEL_OPS)) ops_d = wr_data[SW-1:0];
      if (wr_sel == SEL_W'(SEL_OPD)) opd_d = wr_data;
      if (wr_sel == SEL_W'(SEL_MSK)) msk_d = wr_data;
      if (wr_sel == SEL_W'(SEL_CTL)) ctl_d = wr_data[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_ref_addr <= '0;
      pc_ref_asid <= '0;
      op_ref_addr <= '0;
      op_ref_asid <= '0;
      op_ref_data <= '0;
      op_mask     <= '0;
      ctl_q       <= '0;
    end else begin
      pc_ref_addr <= pca_d;
      pc_ref_asid <= pcs_d;
      op_ref_addr <= opa_d;
      op_ref_asid <= ops_d;
      op_ref_data <= opd_d;
      op_mask     <= msk_d;
      ctl_q       <= ctl_d;
    end
  end

  assign pc_en   = ctl_q[NUM_PC-1:0];
  assign pc_incl = ctl_q[ctl_pc_incl_lsb(NUM_PC) +: NUM_PC];
  assign op_en   = ctl_q[ctl_op_en_bit(NUM_PC)];
  assign op_incl = ctl_q[ctl_op_incl_bit(NUM_PC)];

  // R10: a write to a select beyond the map leaves every register as it was
  assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_W'(SEL_CTL)) |=>
      ($stable(ctl_q) && $stable(pc_ref_addr) && $stable(pc_ref_asid) &&
       $stable(op_ref_addr) && $stable(op_ref_asid) && $stable(op_ref_data) &&
       $stable(op_mask)));
endmodule

// File: rtl/bkpt_pc_cmp.sv
module bkpt_pc_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = ADDR_W_DEF,
  parameter int SW = ASID_W_DEF
) (
  input  logic          en,
  input  logic          incl,
  input  logic [AW-1:0] ref_addr,
  input  logic [SW-1:0] ref_asid,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] asid,
  output logic          hit
);
  logic addr_eq, asid_ok;

  always_comb begin
    addr_eq = (addr == ref_addr);
    asid_ok = !incl || (asid == ref_asid);
    hit     = en && addr_eq && asid_ok;
  end
endmodule

// File: rtl/bkpt_op_cmp.sv
module bkpt_op_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = ADDR_W_DEF,
  parameter int DW = DATA_W_DEF,
  parameter int SW = ASID_W_DEF
) (
  input  logic          en,
  input  logic          incl,
  input  logic [AW-1:0] ref_addr,
  input  logic [SW-1:0] ref_asid,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] mask,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [SW-1:0] asid,
  output logic          hit
);
  logic addr_eq, asid_ok, data_ok;

  always_comb begin
    addr_eq = (addr == ref_addr);
    asid_ok = !incl || (asid == ref_asid);
    data_ok = ((data ^ ref_data) & mask) == '0;
    hit     = en && addr_eq && asid_ok && data_ok;
  end
endmodule

// File: rtl/asid_bkpt_cmp.sv
module asid_bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = NUM_PC_DEF,
  parameter int AW     = ADDR_W_DEF,
  parameter int DW     = DATA_W_DEF,
  parameter int SW     = ASID_W_DEF,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              pc_valid,
  input  logic [AW-1:0]     pc_addr,
  input  logic [SW-1:0]     cur_asid,
  input  logic              op_valid,
  input  logic [AW-1:0]     op_addr,
  input  logic [DW-1:0]     op_data,
  output logic [NUM_PC-1:0] pc_hit_vec,
  output logic              op_hit,
  output logic              trig
);
  logic [NUM_PC-1:0][AW-1:0] pc_ref_addr;
  logic [NUM_PC-1:0][SW-1:0] pc_ref_asid;
  logic [NUM_PC-1:0]         pc_en, pc_incl, pc_hit_c, pc_hit_d;
  logic [AW-1:0]             op_ref_addr;
  logic [SW-1:0]             op_ref_asid;
  logic [DW-1:0]             op_ref_data, op_mask;
  logic                      op_en, op_incl, op_hit_c, op_hit_d, trig_d;

  bkpt_regs #(.NUM_PC(NUM_PC), .AW(AW), .DW(DW), .SW(SW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_ref_addr(pc_ref_addr), .pc_ref_asid(pc_ref_asid), .pc_en(pc_en),
    .pc_incl(pc_incl), .op_ref_addr(op_ref_addr), .op_ref_asid(op_ref_asid),
    .op_ref_data(op_ref_data), .op_mask(op_mask), .op_en(op_en), .op_incl(op_incl)
  );

  for (genvar k = 0; k < NUM_PC; k++) begin : g_pc
    bkpt_pc_cmp #(.AW(AW), .SW(SW)) u_cmp (
      .en(pc_en[k]), .incl(pc_incl[k]), .ref_addr(pc_ref_addr[k]),
      .ref_asid(pc_ref_asid[k]), .addr(pc_addr), .asid(cur_asid), .hit(pc_hit_c[k])
    );

    // R4: a hit bit needs the breakpoint enabled at the compare edge
    assert_pc_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hit_vec[k] |-> $past(pc_en[k]));
    // R2: a hit bit means the presented address equalled the stored one
    assert_pc_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hit_vec[k] |-> ($past(pc_addr) == $past(pc_ref_addr[k])));
    // R3: with inclusion on, the ASID must also have matched
    assert_pc_asid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hit_vec[k] && $past(pc_incl[k])) |-> ($past(cur_asid) == $past(pc_ref_asid[k])));
  end

  bkpt_op_cmp #(.AW(AW), .DW(DW), .SW(SW)) u_op (
    .en(op_en), .incl(op_incl), .ref_addr(op_ref_addr), .ref_asid(op_ref_asid),
    .ref_data(op_ref_data), .mask(op_mask), .addr(op_addr), .data(op_data),
    .asid(cur_asid), .hit(op_hit_c)
  );

  // Next-state: a hit is kept only when its strobe was present.
  always_comb begin
    pc_hit_d = pc_valid ? pc_hit_c : '0;
    op_hit_d = op_valid && op_hit_c;
    trig_d   = (|pc_hit_d) || op_hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_hit_vec <= '0;
      op_hit     <= 1'b0;
      trig       <= 1'b0;
    end else begin
      pc_hit_vec <= pc_hit_d;
      op_hit     <= op_hit_d;
      trig       <= trig_d;
    end
  end

  // R6: no output without a strobe one edge earlier
  assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pc_hit_vec) |-> $past(pc_valid)) and (op_hit |-> $past(op_valid)));
  // R7: operand hit implies enabled breakpoint and equal address
  assert_op_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |-> ($past(op_en) && $past(op_addr) == $past(op_ref_addr)));
  // R8: operand hit implies equal data in every unmasked bit
  assert_op_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |-> ((($past(op_data) ^ $past(op_ref_data)) & $past(op_mask)) == '0));
endmodule

// File: tb/sim_asid_bkpt_cmp.sv
module sim_asid_bkpt_cmp;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic        pc_valid;
  logic [31:0] pc_addr;
  logic [7:0]  cur_asid;
  logic        op_valid;
  logic [31:0] op_addr;
  logic [31:0] op_data;
  logic [3:0]  pc_hit_vec;
  logic        op_hit;
  logic        trig;

  int n_chk = 0;
  int n_bad = 0;

  asid_bkpt_cmp u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_valid(pc_valid), .pc_addr(pc_addr), .cur_asid(cur_asid),
    .op_valid(op_valid), .op_addr(op_addr), .op_data(op_data),
    .pc_hit_vec(pc_hit_vec), .op_hit(op_hit), .trig(trig)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Presents one instruction compare, checks the pulse and its end.
  task automatic pc_try(input string req, input logic [31:0] a, input logic [7:0] s,
                        input logic [3:0] exp);
    @(negedge clk);
    pc_valid = 1'b1; pc_addr = a; cur_asid = s;
    @(negedge clk);
    pc_valid = 1'b0;
    chk(req, {28'd0, pc_hit_vec}, {28'd0, exp});
    chk({req, " R11 trig"}, {31'd0, trig}, {31'd0, |exp});
    @(negedge clk);
    chk({req, " R6 pulse end"}, {27'd0, trig, pc_hit_vec}, 32'd0);
  endtask

  task automatic op_try(input string req, input logic [31:0] a, input logic [31:0] d,
                        input logic [7:0] s, input logic exp);
    @(negedge clk);
    op_valid = 1'b1; op_addr = a; op_data = d; cur_asid = s;
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, {30'd0, trig, op_hit}, {30'd0, exp, exp});
    @(negedge clk);
    chk({req, " R6 pulse end"}, {31'd0, op_hit}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 outputs at reset", {27'd0, trig, op_hit, pc_hit_vec}, 32'd0);
    pc_try("R1 disabled pc", 32'd0, 8'd0, 4'b0000);
    op_try("R1 disabled op", 32'd0, 32'd0, 8'd0, 1'b0);
  endtask

  task automatic t_pc_no_asid;
    wr(4'd0, 32'h0000_1000);
    wr(4'd12, 32'h0000_0001);
    pc_try("R2 match asid 05", 32'h0000_1000, 8'h05, 4'b0001);
    pc_try("R2 match asid AA", 32'h0000_1000, 8'hAA, 4'b0001);
    pc_try("R2 addr miss", 32'h0000_1004, 8'h05, 4'b0000);
  endtask

  task automatic t_pc_asid;
    wr(4'd1, 32'h0000_2000);
    wr(4'd5, 32'h0000_0033);
    wr(4'd12, 32'h0000_0023); // en 0,1; include on 1
    pc_try("R3 asid equal", 32'h0000_2000, 8'h33, 4'b0010);
    pc_try("R3 asid differs", 32'h0000_2000, 8'h34, 4'b0000);
  endtask

  task automatic t_enable_multi;
    wr(4'd2, 32'h0000_4000);
    wr(4'd3, 32'h0000_4000);
    pc_try("R4 disabled pair", 32'h0000_4000, 8'h00, 4'b0000);
    wr(4'd12, 32'h0000_002F); // en 0..3, include on 1
    pc_try("R5 two bits", 32'h0000_4000, 8'h00, 4'b1100);
    wr(4'd12, 32'h0000_0027); // en 0,1,2
    pc_try("R4 reg3 off", 32'h0000_4000, 8'h00, 4'b0100);
  endtask

  task automatic t_no_valid;
    @(negedge clk);
    pc_addr = 32'h0000_1000; cur_asid = 8'h00;
    @(negedge clk);
    chk("R6 no strobe", {27'd0, trig, op_hit, pc_hit_vec}, 32'd0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'h0000_5000;
    pc_valid = 1'b1; pc_addr = 32'h0000_5000; cur_asid = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; pc_valid = 1'b0;
    chk("R9 old value used", {28'd0, pc_hit_vec}, 32'd0);
    pc_try("R9 new value next", 32'h0000_5000, 8'h00, 4'b0001);
  endtask

  task automatic t_operand;
    wr(4'd8, 32'h0000_8000);
    wr(4'd9, 32'h0000_0044);
    wr(4'd10, 32'h1234_5678);
    wr(4'd11, 32'hFFFF_0000);
    wr(4'd12, 32'h0000_0327); // op en + include
    op_try("R7 R8 masked match", 32'h0000_8000, 32'h1234_ABCD, 8'h44, 1'b1);
    op_try("R8 unmasked bit differs", 32'h0000_8000, 32'h1235_5678, 8'h44, 1'b0);
    op_try("R7 asid differs", 32'h0000_8000, 32'h1234_5678, 8'h45, 1'b0);
    op_try("R7 addr differs", 32'h0000_8004, 32'h1234_5678, 8'h44, 1'b0);
    wr(4'd11, 32'h0000_0000);
    op_try("R8 zero mask", 32'h0000_8000, 32'hDEAD_BEEF, 8'h44, 1'b1);
  endtask

  task automatic t_unmapped;
    wr(4'd13, 32'hFFFF_FFFF);
    wr(4'd14, 32'h0000_0000);
    wr(4'd15, 32'h0000_0000);
    pc_try("R10 reg3 still off", 32'h0000_4000, 8'h00, 4'b0100);
    pc_try("R10 reg0 unchanged", 32'h0000_5000, 8'h99, 4'b0001);
    op_try("R10 op unchanged", 32'h0000_8000, 32'h0, 8'h44, 1'b1);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    pc_valid = 1'b0; pc_addr = '0; cur_asid = '0;
    op_valid = 1'b0; op_addr = '0; op_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pc_no_asid();
    t_pc_asid();
    t_enable_multi();
    t_no_valid();
    t_same_edge();
    t_operand();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule